// File: doc/BRIEF.md
# Host–Coprocessor Mailbox Register Block

This block sits between a host processor and a small control coprocessor. The host reaches it through a simple 32-bit register bus with a write strobe and a combinational read port. It holds the coprocessor's run/reset control, a memory-split setting, four extended-memory window bases, a watchdog control word and a read-only program-counter view. It also holds two mailbox registers, one for each direction. Reads have no side effects.

The host rings the coprocessor by writing a command word to the doorbell register. That register reads non-zero until the coprocessor pulses its take strobe, so the host polls it before posting the next command. The return path is a status register that drives a level interrupt to the host. A message from the coprocessor sets bit 8 and a watchdog expiry sets bit 0, so one read tells the host which kind of event it is handling. While the status is non-zero, new events wait in a one-deep pending flag per kind and overwrite nothing. The host acknowledges by writing zero, and the next pending event follows one cycle later.

Top module: `cpmbox_regs`

## Requirements
- R1: Offset 0x00 is run control. Bit 0 is writable and reads back, and bits 31..1 read 0. `cp_run_o` equals bit 0, where 1 means running and 0 means held in reset.
- R2: Offset 0x08 is the memory-split setting. It stores the full 32-bit written value and drives it on `part_cfg_o`. The value 2 selects a 96 KiB program / 32 KiB data split.
- R3: Offsets 0x0C/0x10 are the program window bases 0/1, and 0x14/0x18 are the data window bases 0/1. On each write, bits 11..0 are stored as zero, except that the first register of each pair keeps bit 0 as a window-disable flag (1 means off). After reset, the first registers read 1 and the second registers read 0. `ext_base_o` packs them into 32-bit slices in the order program0, program1, data0, data1, from the low slice up.
- R4: Offset 0x24 is the doorbell. A host write stores the data. `doorbell_o` is high while the value is non-zero. A pulse on `cp_take_i` clears the doorbell at the next edge, unless the host writes it in the same cycle, in which case the host write wins.
- R5: Offset 0x1C is the status register. When the status is zero, a `cp_msg_i` pulse makes it read 0x100 after the next edge, and an enabled watchdog pulse makes it read 0x001.
- R6: `irq_o` is high exactly while the status is non-zero. It goes low right after the edge at which the host writes 0 to offset 0x1C. A host write to 0x1C keeps only bits 8 and 0 of the data.
- R7: While the status is non-zero, or during a host write to it, new events do not change the status. Each kind is held in a single pending flag, and repeated events merge into that flag. A pending event loads into the status at the second edge after the clearing write, which leaves `irq_o` low for one cycle.
- R8: A `wdt_expire_i` pulse has no effect, not even as a pending event, unless bit 31 of the watchdog register is set.
- R9: When a watchdog event and a message event are both ready, the watchdog event (0x001) is loaded first, and the message follows after the host clears the status.
- R10: Offset 0x84 is the watchdog control register. All 32 bits are writable and read back unchanged, and `wdt_en_o` equals bit 31.
- R11: Offset 0x60 reads `pc_i` zero-extended to 32 bits, and host writes to it are discarded. Reads of any unmapped offset return 0, and writes to unmapped offsets have no effect.
- R12: After reset, every register reads 0 except the two first window-base registers (R3), and `irq_o`, `doorbell_o`, `cp_run_o` and `wdt_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | ADDR_W | Host byte offset |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| cp_take_i | input | 1 | Coprocessor has taken the doorbell command |
| cp_msg_i | input | 1 | Coprocessor message event pulse |
| wdt_expire_i | input | 1 | Watchdog expiry pulse |
| pc_i | input | PC_W | Coprocessor program counter |
| cp_run_o | output | 1 | Coprocessor run (1) / reset (0) |
| doorbell_o | output | 1 | Doorbell register non-zero |
| irq_o | output | 1 | Level interrupt to the host |
| part_cfg_o | output | 32 | Memory-split setting |
| ext_base_o | output | 128 | Window bases: program0, program1, data0, data1 |
| wdt_en_o | output | 1 | Watchdog enable (bit 31) |

## Verification
The bench keeps `ADDR_W` at 8 and builds the block with `PC_W` set to 20. A narrow program counter makes the zero-extension of the 0x60 readback observable, because a wrong width shows up as stray upper bits. The 8-bit offset space covers both the unmapped holes between registers and offsets above the last register. The directed part drives event pulses around the status clear, so the one-cycle gap and the delivery order of pending events are checked cycle by cycle.

// File: rtl/cpmbox_pkg.sv
package cpmbox_pkg;
  localparam int DW = 32;
  localparam logic [7:0] OFS_RUN  = 8'h00;
  localparam logic [7:0] OFS_PART = 8'h08;
  localparam logic [7:0] OFS_PX0  = 8'h0C;
  localparam logic [7:0] OFS_PX1  = 8'h10;
  localparam logic [7:0] OFS_DX0  = 8'h14;
  localparam logic [7:0] OFS_DX1  = 8'h18;
  localparam logic [7:0] OFS_C2H  = 8'h1C;
  localparam logic [7:0] OFS_H2C  = 8'h24;
  localparam logic [7:0] OFS_PC   = 8'h60;
  localparam logic [7:0] OFS_WDT  = 8'h84;
  localparam int NWIN = 4;
  localparam logic [DW-1:0] STAT_MSG  = 32'h0000_0100;
  localparam logic [DW-1:0] STAT_WDT  = 32'h0000_0001;
  localparam logic [DW-1:0] STAT_MASK = STAT_MSG | STAT_WDT;
  localparam logic [DW-1:0] PAGE_MASK = 32'hFFFF_F000;
  localparam int WDT_EN_BIT = 31;
endpackage

// File: rtl/cpmbox_extwin.sv
module cpmbox_extwin
  import cpmbox_pkg::*;
#(
  parameter bit IS_FIRST = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] base_o
);
  localparam logic [DW-1:0] KEEP = IS_FIRST ? (PAGE_MASK | 32'h1) : PAGE_MASK;
  localparam logic [DW-1:0] RST  = IS_FIRST ? 32'h1 : 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_o <= RST;
    else if (we_i) base_o <= wdata_i & KEEP;
  end
endmodule

// File: rtl/cpmbox_status.sv
module cpmbox_status
  import cpmbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          msg_i,
  input  logic          wdt_i,
  input  logic          wdt_en_i,
  output logic [DW-1:0] stat_o
);
  logic msg_pend_q, wdt_pend_q;
  logic msg_rdy, wdt_rdy, free;

  assign msg_rdy = msg_pend_q | msg_i;
  assign wdt_rdy = wdt_pend_q | (wdt_i & wdt_en_i);
  assign free    = !we_i && (stat_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o     <= '0;
      msg_pend_q <= 1'b0;
      wdt_pend_q <= 1'b0;
    end else begin
      msg_pend_q <= msg_rdy;
      wdt_pend_q <= wdt_rdy;
      if (we_i) begin
        stat_o <= wdata_i & STAT_MASK;
      end else if (free && wdt_rdy) begin
        stat_o     <= STAT_WDT;  // watchdog outranks messages
        wdt_pend_q <= 1'b0;
      end else if (free && msg_rdy) begin
        stat_o     <= STAT_MSG;
        msg_pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpmbox_regs.sv
module cpmbox_regs
  import cpmbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PC_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                cp_take_i,
  input  logic                cp_msg_i,
  input  logic                wdt_expire_i,
  input  logic [PC_W-1:0]     pc_i,
  output logic                cp_run_o,
  output logic                doorbell_o,
  output logic                irq_o,
  output logic [31:0]         part_cfg_o,
  output logic [NWIN*32-1:0]  ext_base_o,
  output logic                wdt_en_o
);
  localparam logic [7:0] WIN_OFS [NWIN] = '{OFS_PX0, OFS_PX1, OFS_DX0, OFS_DX1};

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] o);
    return a == ADDR_W'(o);
  endfunction

  logic          run_q;
  logic [DW-1:0] part_q, h2c_q, wdt_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      part_q <= '0;
      h2c_q  <= '0;
      wdt_q  <= '0;
    end else begin
      if (wr_en_i && hit(addr_i, OFS_RUN))  run_q  <= wdata_i[0];
      if (wr_en_i && hit(addr_i, OFS_PART)) part_q <= wdata_i;
      if (wr_en_i && hit(addr_i, OFS_WDT))  wdt_q  <= wdata_i;
      if (wr_en_i && hit(addr_i, OFS_H2C))  h2c_q  <= wdata_i;
      else if (cp_take_i)                   h2c_q  <= '0;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    cpmbox_extwin #(.IS_FIRST((g % 2) == 0)) u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && hit(addr_i, WIN_OFS[g])),
      .wdata_i (wdata_i),
      .base_o  (ext_base_o[g*32 +: 32])
    );
  end

  cpmbox_status u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en_i && hit(addr_i, OFS_C2H)),
    .wdata_i  (wdata_i),
    .msg_i    (cp_msg_i),
    .wdt_i    (wdt_expire_i),
    .wdt_en_i (wdt_q[WDT_EN_BIT]),
    .stat_o   (stat_q)
  );

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, OFS_RUN))  rdata_o = {31'b0, run_q};
    if (hit(addr_i, OFS_PART)) rdata_o = part_q;
    if (hit(addr_i, OFS_C2H))  rdata_o = stat_q;
    if (hit(addr_i, OFS_H2C))  rdata_o = h2c_q;
    if (hit(addr_i, OFS_PC))   rdata_o = 32'(pc_i);
    if (hit(addr_i, OFS_WDT))  rdata_o = wdt_q;
    for (int i = 0; i < NWIN; i++)
      if (hit(addr_i, WIN_OFS[i])) rdata_o = ext_base_o[i*32 +: 32];
  end

  assign cp_run_o   = run_q;
  assign part_cfg_o = part_q;
  assign doorbell_o = |h2c_q;
  assign irq_o      = |stat_q;
  assign wdt_en_o   = wdt_q[WDT_EN_BIT];
endmodule

// File: rtl/cpmbox_regs_chk.sv
module cpmbox_regs_chk
  import cpmbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              cp_take_i,
  input logic              cp_run_o,
  input logic              doorbell_o,
  input logic              irq_o,
  input logic [NWIN*32-1:0] ext_base_o,
  input logic [31:0]       stat_i
);
  logic wr_run, wr_h2c, wr_c2h;
  assign wr_run = wr_en_i && addr_i == ADDR_W'(OFS_RUN);
  assign wr_h2c = wr_en_i && addr_i == ADDR_W'(OFS_H2C);
  assign wr_c2h = wr_en_i && addr_i == ADDR_W'(OFS_C2H);

  a_r1_run_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_run |=> cp_run_o == $past(wdata_i[0]));
  a_r4_bell_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_h2c && wdata_i != 0) |=> doorbell_o);
  a_r4_bell_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_take_i && !wr_h2c) |=> !doorbell_o);
  a_r6_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c2h && !wdata_i[8] && !wdata_i[0]) |=> !irq_o);
  a_r7_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i != 0 && !wr_c2h) |=> $stable(stat_i));
  a_r3_page_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_base_o[32 +: 12] == 12'h0 && ext_base_o[96 +: 12] == 12'h0
    && ext_base_o[1 +: 11] == 11'h0 && ext_base_o[65 +: 11] == 11'h0);
endmodule

bind cpmbox_regs cpmbox_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .cp_take_i  (cp_take_i),
  .cp_run_o   (cp_run_o),
  .doorbell_o (doorbell_o),
  .irq_o      (irq_o),
  .ext_base_o (ext_base_o),
  .stat_i     (stat_q)
);

// File: tb/cpmbox_regs_test.sv
module cpmbox_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 20;
  localparam logic [PC_W-1:0] PC_VAL = 20'hA5A5A;

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, cp_take = 0, cp_msg = 0, wdt_exp = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata, part_cfg;
  logic [127:0] ext_base;
  logic cp_run, doorbell, irq, wdt_en;
  int total = 0, bad = 0;

  cpmbox_regs #(.ADDR_W(8), .PC_W(PC_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cp_take_i(cp_take), .cp_msg_i(cp_msg), .wdt_expire_i(wdt_exp),
    .pc_i(PC_VAL), .cp_run_o(cp_run), .doorbell_o(doorbell), .irq_o(irq),
    .part_cfg_o(part_cfg), .ext_base_o(ext_base), .wdt_en_o(wdt_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {write, offset, data, expected readback}
  localparam int NV = 11;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0000_0001, 32'h0000_0001},  // R1
    {1'b1, 8'h00, 32'hFFFF_FFFE, 32'h0000_0000},  // R1
    {1'b1, 8'h08, 32'h0000_0002, 32'h0000_0002},  // R2
    {1'b1, 8'h0C, 32'h1234_5FFF, 32'h1234_5001},  // R3
    {1'b1, 8'h10, 32'hABCD_EFFF, 32'hABCD_E000},  // R3
    {1'b1, 8'h14, 32'h0000_0001, 32'h0000_0001},  // R3
    {1'b1, 8'h18, 32'h8000_0123, 32'h8000_0000},  // R3
    {1'b1, 8'h84, 32'h8000_00A5, 32'h8000_00A5},  // R10
    {1'b1, 8'h60, 32'hFFFF_FFFF, 32'h000A_5A5A},  // R11
    {1'b1, 8'h04, 32'h0000_DEAD, 32'h0000_0000},  // R11
    {1'b0, 8'h40, 32'h0000_0000, 32'h0000_0000}   // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic tick; @(negedge clk); endtask

  initial begin
    #(CLK_PERIOD*20000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1;
    // R12 reset state
    rd("R12", 8'h00, 0); rd("R12", 8'h0C, 1); rd("R12", 8'h10, 0);
    rd("R12", 8'h84, 0); rd("R12", 8'h1C, 0); rd("R12", 8'h24, 0);
    chk("R12", {28'b0, irq, doorbell, cp_run, wdt_en}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      rd("R1/R2/R3/R10/R11 table", VEC[i][71:64], VEC[i][31:0]);
    end
    chk("R10", {31'b0, wdt_en}, 1);
    chk("R2", part_cfg, 2);
    chk("R3", ext_base, {32'h8000_0000, 32'h1, 32'hABCD_E000, 32'h1234_5001});
    wr(8'h00, 1); chk("R1", {31'b0, cp_run}, 1);

    // R4 doorbell
    wr(8'h24, 1); rd("R4", 8'h24, 1); chk("R4", {31'b0, doorbell}, 1);
    @(negedge clk); cp_take = 1; @(negedge clk); cp_take = 0;
    rd("R4", 8'h24, 0); chk("R4", {31'b0, doorbell}, 0);
    @(negedge clk); cp_take = 1; wr_en = 1; addr = 8'h24; wdata = 3;
    @(negedge clk); cp_take = 0; wr_en = 0; rd("R4 host wins", 8'h24, 3);
    wr(8'h24, 0);

    // R5 message, R7 hold, R6 clear
    @(negedge clk); cp_msg = 1; @(negedge clk); cp_msg = 0;
    rd("R5", 8'h1C, 32'h100); chk("R6", {31'b0, irq}, 1);
    @(negedge clk); cp_msg = 1; @(negedge clk); cp_msg = 0;
    rd("R7", 8'h1C, 32'h100);
    wr(8'h1C, 0);
    rd("R6", 8'h1C, 0); chk("R6 irq low", {31'b0, irq}, 0);
    tick; rd("R7 pending", 8'h1C, 32'h100); chk("R7", {31'b0, irq}, 1);
    wr(8'h1C, 0); tick; rd("R7 merged", 8'h1C, 0);
    wr(8'h1C, 32'hFFFF_FFFF); rd("R6 mask", 8'h1C, 32'h101);
    wr(8'h1C, 0); tick;

    // R8 watchdog disabled
    wr(8'h84, 32'h7FFF_FFFF);
    @(negedge clk); wdt_exp = 1; @(negedge clk); wdt_exp = 0;
    tick; rd("R8", 8'h1C, 0); chk("R8", {31'b0, irq}, 0);
    wr(8'h84, 32'h8000_0000);
    tick; rd("R8 no pending", 8'h1C, 0);
    @(negedge clk); wdt_exp = 1; @(negedge clk); wdt_exp = 0;
    rd("R5 wdt", 8'h1C, 32'h001);

    // R9 priority
    wr(8'h1C, 0); tick;
    @(negedge clk); wdt_exp = 1; cp_msg = 1; @(negedge clk); wdt_exp = 0; cp_msg = 0;
    rd("R9", 8'h1C, 32'h001);
    wr(8'h1C, 0); tick; rd("R9", 8'h1C, 32'h100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule